// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns parallel characters into asynchronous serial frames on a single line. A character is handed over with a valid/ready handshake. The block then drives a low start bit and the data bits, least significant first. An optional parity bit follows, then a high stop period, after which the line returns to the high idle level. Time is measured by counting an oversampling clock enable that runs at 16, 32 or 64 times the bit rate. Every bit lasts sixteen "sixteenths", and each sixteenth is one, two or four oversampling ticks.

The frame settings are sampled when a character is accepted and stay fixed for that character. They are the character length (one to eight bits), the parity mode (none, even, odd, forced one, forced zero), the oversampling ratio and the stop time. The stop time is set in sixteenths of a bit, from one sixteenth to two full bits. A break input overrides the line to the low (space) level for as long as it is held, and no new character is taken while it is held.

The block is meant to sit behind a transmit FIFO and next to a baud-rate generator that supplies the tick.

Top module: `serial_async_tx`

## Requirements
- R1: After reset, with `brk` low, `txd` is high and `in_ready` is high.
- R2: A frame is a start bit, low for one bit time (16 sixteenths), followed by `cfg_len`+1 data bits. The data bits are sent least significant bit first and each lasts one bit time.
- R3: `cfg_par` codes are 3'b000 none, 3'b001 even, 3'b010 odd, 3'b011 forced one, 3'b100 forced zero, and 3'b101 to 3'b111 none. When parity is enabled, one parity bit of one bit time follows the last data bit. Even and odd parity are counted over the `cfg_len`+1 data bits only.
- R4: `cfg_ratio` 2'b00 gives one oversampling tick per sixteenth (16x), 2'b01 gives two (32x), and 2'b10 or 2'b11 gives four (64x). The stop step therefore stays one sixteenth of a bit at every ratio.
- R5: The stop period holds `txd` high for `cfg_stop`+1 sixteenths, 1 to 32.
- R6: A character is accepted at a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from that edge until the last stop sixteenth has elapsed, and it is high again in the cycle right after. This allows back-to-back characters.
- R7: Frame timing advances only on cycles with `os_tick` high. On other cycles the line and the frame position hold.
- R8: While `brk` is high, `txd` is low and `in_ready` is low, so no character is accepted. When `brk` falls in idle, the line returns high.
- R9: Changes to `cfg_len`, `cfg_par`, `cfg_stop` and `cfg_ratio` after a character has been accepted have no effect on that character's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling clock enable |
| cfg_ratio | input | 2 | Oversampling ratio select |
| cfg_len | input | 3 | Character length minus one |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 5 | Stop time in sixteenths minus one |
| brk | input | 1 | Hold the line at space (break) |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character, LSB sent first |
| in_ready | output | 1 | Transmitter can take a character |
| txd | output | 1 | Serial line, high when idle |

## Verification
The bench builds the block with its default parameters: eight-bit characters, a five-bit stop field and parity logic included. These defaults make all three tick-per-sixteenth scalings reachable, along with the whole 1-to-32 sixteenth stop range, every parity code and the one-bit and eight-bit character lengths. The bench follows the frame position by counting the ticks it applies itself, so tick patterns with gaps test the hold behaviour against the same expected waveform. Scrambling the configuration right after each handshake shows that the frame settings are latched.

// File: rtl/sat_pkg.sv
package sat_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } sat_state_e;

   localparam logic [2:0] PAR_NONE  = 3'b000;
   localparam logic [2:0] PAR_EVEN  = 3'b001;
   localparam logic [2:0] PAR_ODD   = 3'b010;
   localparam logic [2:0] PAR_ONE   = 3'b011;
   localparam logic [2:0] PAR_ZERO  = 3'b100;

   localparam int SIXTEENTHS_PER_BIT = 16;
endpackage

// File: rtl/sat_subdiv.sv
module sat_subdiv (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       os_tick,
   input  logic [1:0] ratio,
   output logic       six_tk
);
   localparam int DIV_W = 2;

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   always_comb begin
      case (ratio)
         2'b00:   lim = DIV_W'(0);
         2'b01:   lim = DIV_W'(1);
         default: lim = DIV_W'(3);
      endcase
   end

   assign six_tk = os_tick && (cnt == lim) && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (os_tick) begin
         if (cnt == lim) cnt <= '0;
         else            cnt <= cnt + DIV_W'(1);
      end
   end

   // R4: the tick divider never passes the limit chosen by the ratio
   assert_div_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> cnt <= lim);
endmodule

// File: rtl/sat_parity.sv
module sat_parity #(
   parameter int DATA_W = 8,
   parameter bit PAR_EN = 1'b1,
   localparam int LEN_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LEN_W-1:0]  len,
   input  logic [2:0]        mode,
   output logic              pen,
   output logic              pbit
);
   import sat_pkg::*;

   logic [DATA_W-1:0] masked;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign masked[i] = data[i] && (LEN_W'(i) <= len);
   end

   if (PAR_EN) begin : g_par
      always_comb begin
         pen  = 1'b1;
         pbit = 1'b0;
         case (mode)
            PAR_EVEN: pbit = ^masked;
            PAR_ODD:  pbit = ~(^masked);
            PAR_ONE:  pbit = 1'b1;
            PAR_ZERO: pbit = 1'b0;
            default:  pen  = 1'b0;
         endcase
      end
   end else begin : g_nopar
      logic unused_ok;
      assign unused_ok = ^{masked, mode};
      assign pen  = 1'b0;
      assign pbit = 1'b0;
   end
endmodule

// File: rtl/sat_seq.sv
module sat_seq #(
   parameter int DATA_W = 8,
   parameter int STOP_W = 5,
   localparam int LEN_W = $clog2(DATA_W),
   localparam int SUB_W = (STOP_W > 4) ? STOP_W : 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic                 six_tk,
   input  logic [DATA_W-1:0]    data,
   input  logic [LEN_W-1:0]     len,
   input  logic                 pen,
   input  logic                 pbit,
   input  logic [STOP_W-1:0]    stop,
   output sat_pkg::sat_state_e  state,
   output logic                 line
);
   import sat_pkg::*;

   localparam logic [SUB_W-1:0] BIT_LAST = SUB_W'(SIXTEENTHS_PER_BIT - 1);

   logic [SUB_W-1:0]  sub;
   logic [LEN_W-1:0]  bitn;
   logic [DATA_W-1:0] sh;
   logic [LEN_W-1:0]  len_q;
   logic [STOP_W-1:0] stop_q;
   logic              pen_q;
   logic              pbit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sub    <= '0;
         bitn   <= '0;
         sh     <= '0;
         len_q  <= '0;
         stop_q <= '0;
         pen_q  <= 1'b0;
         pbit_q <= 1'b0;
      end else if (accept) begin
         state  <= ST_START;
         sub    <= '0;
         bitn   <= '0;
         sh     <= data;
         len_q  <= len;
         stop_q <= stop;
         pen_q  <= pen;
         pbit_q <= pbit;
      end else if (six_tk) begin
         case (state)
            ST_START: begin
               if (sub == BIT_LAST) begin
                  sub   <= '0;
                  state <= ST_DATA;
               end else sub <= sub + SUB_W'(1);
            end
            ST_DATA: begin
               if (sub == BIT_LAST) begin
                  sub <= '0;
                  if (bitn == len_q) begin
                     state <= pen_q ? ST_PAR : ST_STOP;
                  end else begin
                     bitn <= bitn + LEN_W'(1);
                     sh   <= sh >> 1;
                  end
               end else sub <= sub + SUB_W'(1);
            end
            ST_PAR: begin
               if (sub == BIT_LAST) begin
                  sub   <= '0;
                  state <= ST_STOP;
               end else sub <= sub + SUB_W'(1);
            end
            ST_STOP: begin
               if (sub == SUB_W'(stop_q)) begin
                  sub   <= '0;
                  state <= ST_IDLE;
               end else sub <= sub + SUB_W'(1);
            end
            default: sub <= '0;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_START: line = 1'b0;
         ST_DATA:  line = sh[0];
         ST_PAR:   line = pbit_q;
         default:  line = 1'b1;
      endcase
   end

   // R7: without a sixteenth tick an active frame keeps its position
   assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!six_tk && state != ST_IDLE) |=> ($stable(state) && $stable(sub) && $stable(bitn)));

   // R5: the stop counter never runs past the latched stop length
   assert_stop_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_STOP |-> sub <= SUB_W'(stop_q));

   // R2: the data bit index never exceeds the latched character length
   assert_bit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DATA |-> bitn <= len_q);
endmodule

// File: rtl/serial_async_tx.sv
module serial_async_tx #(
   parameter int DATA_W = 8,
   parameter int STOP_W = 5,
   parameter bit PAR_EN = 1'b1,
   localparam int LEN_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic [1:0]        cfg_ratio,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [2:0]        cfg_par,
   input  logic [STOP_W-1:0] cfg_stop,
   input  logic              brk,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              txd
);
   import sat_pkg::*;

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_data
      $error("serial_async_tx: DATA_W must be a power of two of at least 2");
   end
   if (STOP_W < 1 || STOP_W > 8) begin : g_chk_stop
      $error("serial_async_tx: STOP_W must be in 1..8");
   end

   sat_state_e state;
   logic       line;
   logic       accept;
   logic       six_tk;
   logic       pen;
   logic       pbit;
   logic [1:0] ratio_q;

   assign in_ready = (state == ST_IDLE) && !brk;
   assign accept   = in_valid && in_ready;
   assign txd      = brk ? 1'b0 : line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ratio_q <= 2'b00;
      else if (accept) ratio_q <= cfg_ratio;
   end

   sat_subdiv u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state == ST_IDLE),
      .os_tick (os_tick),
      .ratio   (ratio_q),
      .six_tk  (six_tk)
   );

   sat_parity #(.DATA_W(DATA_W), .PAR_EN(PAR_EN)) u_par (
      .data (in_data),
      .len  (cfg_len),
      .mode (cfg_par),
      .pen  (pen),
      .pbit (pbit)
   );

   sat_seq #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .six_tk (six_tk),
      .data   (in_data),
      .len    (cfg_len),
      .pen    (pen),
      .pbit   (pbit),
      .stop   (cfg_stop),
      .state  (state),
      .line   (line)
   );

   // R6: a handshake closes the input until the frame has been sent
   assert_accept_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R2: the cycle after an accepted character the line is at start level
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !txd);

   // R8: a break held in idle leaves the transmitter idle
   assert_brk_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && state == ST_IDLE) |=> state == ST_IDLE);

   // R1: an idle transmitter with no break shows mark on the line
   assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> (in_ready || brk || $past(brk)) && (txd || brk));
endmodule

// File: tb/serial_async_tx_tb.sv
module serial_async_tx_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic [1:0] cfg_ratio = 2'b00;
   logic [2:0] cfg_len = 3'd7;
   logic [2:0] cfg_par = 3'b000;
   logic [4:0] cfg_stop = 5'd15;
   logic       brk = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       txd;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // expected-frame description
   logic [7:0] e_d;
   int e_n, e_pe, e_s, e_stop, e_T;
   logic e_pb;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_async_tx dut_i (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg_ratio(cfg_ratio),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop), .brk(brk),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
   );

   task automatic ck(input logic act, input logic exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic exp_line(int p);
      int u, b;
      if (p >= e_T) return 1'b1;
      u = p / e_s;
      b = u / 16;
      if (b == 0) return 1'b0;
      if (b <= e_n) return e_d[b-1];
      if (e_pe != 0 && b == e_n + 1) return e_pb;
      return 1'b1;
   endfunction

   // one frame: configure, hand over, follow tick-by-tick, check line and ready
   task automatic send_frame(input logic [7:0] d, input int nbits, input logic [2:0] pm,
                             input int stopn, input logic [1:0] ratio, input int gap,
                             input string tag);
      int p, k, ones;
      logic [7:0] msk;
      msk = 8'hFF >> (8 - nbits);
      ones = $countones(d & msk);
      e_d = d; e_n = nbits; e_stop = stopn;
      e_s = (ratio == 2'b00) ? 1 : (ratio == 2'b01) ? 2 : 4;
      e_pe = 1;
      case (pm)
         3'b001:  e_pb = (ones % 2) != 0;
         3'b010:  e_pb = (ones % 2) == 0;
         3'b011:  e_pb = 1'b1;
         3'b100:  e_pb = 1'b0;
         default: begin e_pe = 0; e_pb = 1'b0; end
      endcase
      e_T = e_s * (16 * (1 + nbits + e_pe) + stopn);
      @(negedge clk);
      ck(in_ready, 1'b1, {tag, " R6 ready before handover"});
      ck(txd, 1'b1, {tag, " R1 idle line before handover"});
      cfg_len = 3'(nbits - 1); cfg_par = pm; cfg_stop = 5'(stopn - 1); cfg_ratio = ratio;
      in_data = d; in_valid = 1'b1; os_tick = 1'b1;
      @(posedge clk);
      p = 0; k = 0;
      for (int guard = 0; guard < 20000; guard++) begin
         @(negedge clk);
         in_valid = 1'b0;
         // R9: scramble the settings while the frame is in flight
         cfg_len = ~cfg_len; cfg_par = cfg_par ^ 3'b011; cfg_stop = ~cfg_stop; cfg_ratio = ~cfg_ratio;
         ck(txd, exp_line(p), {tag, " R2 R3 R4 R5 R9 line"});
         ck(in_ready, (p >= e_T), {tag, " R6 ready"});
         if (p >= e_T) break;
         k++;
         os_tick = ((k % gap) == 0);
         @(posedge clk);
         if (os_tick) p++;
      end
      os_tick = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      ck(txd, 1'b1, "R1 txd after reset");
      ck(in_ready, 1'b1, "R1 in_ready after reset");
   endtask

   task automatic t_break();
      @(negedge clk);
      brk = 1'b1; in_valid = 1'b1; in_data = 8'hA5; os_tick = 1'b1;
      #1;
      ck(txd, 1'b0, "R8 txd low same cycle as break");
      ck(in_ready, 1'b0, "R8 ready low during break");
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         ck(txd, 1'b0, "R8 line held at space");
         ck(in_ready, 1'b0, "R8 no acceptance during break");
      end
      brk = 1'b0; in_valid = 1'b0; os_tick = 1'b0;
      #1;
      ck(txd, 1'b1, "R8 line back to mark after break, no frame started");
      ck(in_ready, 1'b1, "R8 ready back after break");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      send_frame(8'hC5, 8, 3'b000, 16, 2'b00, 1, "8N 16x R2");
      send_frame(8'h01, 1, 3'b001, 16, 2'b00, 1, "1-bit even R3");
      send_frame(8'h5B, 7, 3'b010, 8,  2'b01, 1, "7-bit odd 32x R3 R4");
      send_frame(8'h12, 5, 3'b011, 20, 2'b10, 1, "5-bit mark 64x R3 R4");
      send_frame(8'h3F, 6, 3'b100, 1,  2'b11, 1, "6-bit space stop1 R3 R5");
      send_frame(8'hFF, 8, 3'b001, 32, 2'b10, 1, "8E stop32 64x R5");
      send_frame(8'h80, 8, 3'b111, 3,  2'b00, 1, "code7 no parity R3");
      send_frame(8'h6A, 8, 3'b010, 24, 2'b01, 3, "gapped ticks R7");
      send_frame(8'h93, 4, 3'b001, 5,  2'b00, 2, "gapped ticks 16x R7");
      send_frame(8'hE7, 8, 3'b000, 16, 2'b00, 1, "back-to-back R6");
      t_break();
      send_frame(8'h2C, 8, 3'b001, 16, 2'b00, 1, "after break R8");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule